// File: doc/BRIEF.md
# Ripple-Carry ALU with Signed Compare

This block is a purely combinational arithmetic and logic unit for a 32-bit datapath. It is assembled from a chain of one-bit slices. Each slice holds a full adder and a small result selector, and the carry ripples from bit 0 up to the top bit. A four-bit operation code picks one of six functions: bitwise AND, OR and NOR; addition; subtraction; and a signed "set if less than" compare. One control line inverts operand b and also forces the carry into bit 0, so the same adder chain computes a minus b in two's complement.

The signed compare uses no separate comparator. The most significant slice produces a "set" signal, which is the sign of the internal difference corrected by the overflow condition. That signal loops back to the "less" input of slice 0, and the less inputs of every other slice are tied low. The block also drives two flags. The zero flag is high whenever every result bit is clear. The overflow flag reports signed overflow, and only for addition and subtraction. The block sits in the execute stage of a simple processor between the register read ports and the result bus.

Top module: `ripple_alu`

## Requirements
- R1: Code 4'b0000 gives a AND b, code 4'b0001 gives a OR b, and code 4'b1100 gives NOT(a OR b), each applied bit by bit.
- R2: Code 4'b0010 gives a + b modulo 2^32, and any carry out of bit 31 is dropped.
- R3: Code 4'b0110 gives a - b modulo 2^32 in two's complement.
- R4: Code 4'b0111 gives 32'd1 when a is less than b as signed 32-bit values and 32'd0 otherwise, with bits 31:1 always clear. The answer stays correct when a - b overflows.
- R5: The zero output is 1 exactly when all 32 result bits are 0, for every operation code.
- R6: For addition, overflow is 1 exactly when a[31] equals b[31] and result[31] differs from a[31].
- R7: For subtraction, overflow is 1 exactly when a[31] differs from b[31] and result[31] differs from a[31].
- R8: For codes 4'b0000, 4'b0001, 4'b0111 and 4'b1100, overflow is 0, including when the internal difference overflows during a compare.
- R9: Any other operation code gives result 32'd0, zero 1 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand (subtrahend for subtract and compare) |
| op | input | 4 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when every result bit is 0 |
| overflow | output | 1 | Signed overflow for add and subtract |

## Verification
The immediate assertions in the top module check, on every input change, that the rippled sum and difference match plain arithmetic. They also check that the compare returns the signed ordering in bit 0 with the upper bits clear, that the add overflow follows the sign rule, and that overflow never rises outside add and subtract. The bench scenarios cover what those checks do not: the exact bitwise logic results and the zero flag in its boundary cases, such as a sum that wraps to zero or the subtraction of equal operands. They also cover compares whose difference overflows at the signed extremes, and the all-zero output for unused operation codes.

// File: rtl/ralu_pkg.sv
package ralu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [2:0] {
        SEL_AND,
        SEL_OR,
        SEL_SUM,
        SEL_LESS,
        SEL_NOR,
        SEL_NONE
    } slice_sel_e;

    typedef struct packed {
        logic       b_invert;
        logic       carry_in;
        slice_sel_e sel;
        logic       ovf_enable;
    } alu_ctrl_t;

endpackage

// File: rtl/ralu_decode.sv
module ralu_decode
    import ralu_pkg::*;
(
    input  logic [3:0] op,
    output alu_ctrl_t  ctrl
);

    alu_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d.b_invert   = 1'b0;
        ctrl_d.carry_in   = 1'b0;
        ctrl_d.sel        = SEL_NONE;
        ctrl_d.ovf_enable = 1'b0;
        case (op)
            OP_AND: ctrl_d.sel = SEL_AND;
            OP_OR:  ctrl_d.sel = SEL_OR;
            OP_NOR: ctrl_d.sel = SEL_NOR;
            OP_ADD: begin
                ctrl_d.sel        = SEL_SUM;
                ctrl_d.ovf_enable = 1'b1;
            end
            OP_SUB: begin
                ctrl_d.sel        = SEL_SUM;
                ctrl_d.b_invert   = 1'b1;
                ctrl_d.carry_in   = 1'b1;
                ctrl_d.ovf_enable = 1'b1;
            end
            OP_SLT: begin
                ctrl_d.sel      = SEL_LESS;
                ctrl_d.b_invert = 1'b1;
                ctrl_d.carry_in = 1'b1;
            end
            default: ctrl_d.sel = SEL_NONE;
        endcase
    end

    assign ctrl = ctrl_d;

endmodule

// File: rtl/ralu_slice.sv
module ralu_slice
    import ralu_pkg::*;
#(
    parameter bit IS_MSB = 1'b0
) (
    input  logic       a,
    input  logic       b,
    input  logic       b_invert,
    input  logic       carry_in,
    input  logic       less,
    input  slice_sel_e sel,
    output logic       result,
    output logic       carry_out,
    output logic       set,
    output logic       ovf
);

    logic b_eff;
    logic sum_d;

    assign b_eff     = b ^ b_invert;
    assign sum_d     = a ^ b_eff ^ carry_in;
    assign carry_out = (a & b_eff) | (a & carry_in) | (b_eff & carry_in);

    always_comb begin
        case (sel)
            SEL_AND:  result = a & b;
            SEL_OR:   result = a | b;
            SEL_SUM:  result = sum_d;
            SEL_LESS: result = less;
            SEL_NOR:  result = ~(a | b);
            default:  result = 1'b0;
        endcase
    end

    generate
        if (IS_MSB) begin : g_msb
            logic ovf_d;
            // operands of equal effective sign with a sum of the other sign
            assign ovf_d = (a == b_eff) && (sum_d != a);
            assign ovf   = ovf_d;
            // sign of the true difference, corrected when it overflows
            assign set   = sum_d ^ ovf_d;
        end else begin : g_inner
            assign ovf = 1'b0;
            assign set = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/ralu_zero.sv
module ralu_zero #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] vec,
    output logic             all_zero
);

    assign all_zero = ~|vec;

endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
    import ralu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       op,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow
);

    localparam int MSB = WIDTH - 1;

    alu_ctrl_t        ctrl;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] set_w;
    logic [WIDTH-1:0] ovf_w;
    logic [WIDTH-1:0] less_w;
    logic             ovf_d;

    ralu_decode u_decode (
        .op   (op),
        .ctrl (ctrl)
    );

    assign carry[0] = ctrl.carry_in;
    // only bit 0 hears the compare outcome; the rest read zero
    assign less_w   = {{(WIDTH-1){1'b0}}, set_w[MSB]};

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_slice
            ralu_slice #(
                .IS_MSB (gi == MSB)
            ) u_slice (
                .a         (a[gi]),
                .b         (b[gi]),
                .b_invert  (ctrl.b_invert),
                .carry_in  (carry[gi]),
                .less      (less_w[gi]),
                .sel       (ctrl.sel),
                .result    (result[gi]),
                .carry_out (carry[gi+1]),
                .set       (set_w[gi]),
                .ovf       (ovf_w[gi])
            );
        end
    endgenerate

    assign ovf_d    = ovf_w[MSB] & ctrl.ovf_enable;
    assign overflow = ovf_d;

    ralu_zero #(
        .WIDTH (WIDTH)
    ) u_zero (
        .vec      (result),
        .all_zero (zero)
    );

    always_comb begin
        if (op == OP_ADD) begin
            AST_ADD_SUM: assert (result == a + b) else $error("add mismatch"); // R2
            AST_ADD_OVF: assert (overflow == ((a[MSB] == b[MSB]) && (result[MSB] != a[MSB]))) else $error("add ovf"); // R6
        end
        if (op == OP_SUB) begin
            AST_SUB_DIFF: assert (result == a - b) else $error("sub mismatch"); // R3
        end
        if (op == OP_SLT) begin
            AST_SLT_VALUE: assert (result == {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))}) else $error("slt mismatch"); // R4
        end
        if (overflow) begin
            AST_OVF_ARITH_ONLY: assert (op == OP_ADD || op == OP_SUB) else $error("ovf outside add/sub"); // R8
        end
        if (op == OP_AND && (a & b) == '0) begin
            AST_ZERO_ON_AND: assert (zero) else $error("zero flag low"); // R5
        end
    end

endmodule

// File: tb/ripple_alu_bench.sv
module ripple_alu_bench;

    logic        clk = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [3:0]  op = 4'b0000;
    logic [31:0] result;
    logic        zero;
    logic        overflow;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #10 clk = ~clk;

    ripple_alu u_ripple_alu (
        .a        (a),
        .b        (b),
        .op       (op),
        .result   (result),
        .zero     (zero),
        .overflow (overflow)
    );

    task automatic golden(input logic [31:0] x, input logic [31:0] y, input logic [3:0] code,
                          output logic [31:0] r, output logic z, output logic v);
        logic [32:0] wide;
        v = 1'b0;
        case (code)
            4'b0000: r = x & y;
            4'b0001: r = x | y;
            4'b1100: r = ~(x | y);
            4'b0010: begin
                wide = {1'b0, x} + {1'b0, y};
                r = wide[31:0];
                v = (x[31] == y[31]) && (r[31] != x[31]);
            end
            4'b0110: begin
                wide = {1'b0, x} - {1'b0, y};
                r = wide[31:0];
                v = (x[31] != y[31]) && (r[31] != x[31]);
            end
            4'b0111: r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            default: r = 32'd0;
        endcase
        z = (r == 32'd0);
    endtask

    task automatic apply_check(input string tag, input logic [31:0] x, input logic [31:0] y,
                               input logic [3:0] code);
        logic [31:0] er;
        logic        ez;
        logic        ev;
        @(negedge clk);
        a  = x;
        b  = y;
        op = code;
        #2;
        golden(x, y, code, er, ez, ev);
        checks++;
        if (result !== er || zero !== ez || overflow !== ev) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h: actual res=%h z=%b v=%b expected res=%h z=%b v=%b",
                     tag, code, x, y, result, zero, overflow, er, ez, ev);
        end
    endtask

    function automatic logic [31:0] next_lfsr(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic t_idle();
        #2;
        checks++;
        if (result !== 32'd0 || zero !== 1'b1 || overflow !== 1'b0) begin
            errors++;
            $display("FAIL R5 idle: actual res=%h z=%b v=%b expected res=0 z=1 v=0", result, zero, overflow);
        end
    endtask

    task automatic t_logic();
        apply_check("R1 and", 32'hF0F0_1234, 32'hFF00_FF0F, 4'b0000);
        apply_check("R1 or",  32'hF0F0_1234, 32'h0F00_00F0, 4'b0001);
        apply_check("R1 nor", 32'hF0F0_1234, 32'h0F00_00F0, 4'b1100);
        apply_check("R1 nor all ones", 32'hFFFF_FFFF, 32'h0, 4'b1100);
    endtask

    task automatic t_add();
        apply_check("R2 add small", 32'd100, 32'd23, 4'b0010);
        apply_check("R2 add carry out", 32'hFFFF_FFFF, 32'h0000_0002, 4'b0010);
        apply_check("R6 add pos ovf", 32'h7FFF_FFFF, 32'h0000_0001, 4'b0010);
        apply_check("R6 add neg ovf", 32'h8000_0000, 32'h8000_0000, 4'b0010);
        apply_check("R6 add mixed no ovf", 32'h8000_0000, 32'h7FFF_FFFF, 4'b0010);
    endtask

    task automatic t_sub();
        apply_check("R3 sub", 32'd50, 32'd75, 4'b0110);
        apply_check("R7 sub pos ovf", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0110);
        apply_check("R7 sub neg ovf", 32'h8000_0000, 32'h0000_0001, 4'b0110);
        apply_check("R7 sub same sign", 32'h8000_0000, 32'h8000_0000, 4'b0110);
    endtask

    task automatic t_slt();
        apply_check("R4 slt less", 32'hFFFF_FFFE, 32'd3, 4'b0111);
        apply_check("R4 slt greater", 32'd3, 32'hFFFF_FFFE, 4'b0111);
        apply_check("R4 slt equal", 32'd9, 32'd9, 4'b0111);
        apply_check("R4 slt ovf less", 32'h8000_0000, 32'h0000_0001, 4'b0111);
        apply_check("R4 slt ovf greater", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
        apply_check("R4 slt extremes", 32'h8000_0000, 32'h7FFF_FFFF, 4'b0111);
    endtask

    task automatic t_zero();
        apply_check("R5 add wraps to zero", 32'h0000_0001, 32'hFFFF_FFFF, 4'b0010);
        apply_check("R5 sub equal", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'b0110);
        apply_check("R5 or nonzero", 32'h0, 32'h8000_0000, 4'b0001);
    endtask

    task automatic t_ovf_gated();
        apply_check("R8 slt diff ovf", 32'h7FFF_FFFF, 32'h8000_0000, 4'b0111);
        apply_check("R8 and signs", 32'h8000_0000, 32'h8000_0000, 4'b0000);
        apply_check("R8 or signs", 32'h7FFF_FFFF, 32'h0000_0001, 4'b0001);
        apply_check("R8 nor", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 4'b1100);
    endtask

    task automatic t_undefined();
        logic [3:0] bad [6] = '{4'b0011, 4'b0100, 4'b0101, 4'b1000, 4'b1101, 4'b1111};
        for (int k = 0; k < 6; k++) begin
            apply_check("R9 unused code", 32'hFFFF_FFFF, 32'h1234_5678, bad[k]);
        end
    endtask

    task automatic t_sweep();
        logic [3:0] ops [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
        logic [31:0] x;
        for (int n = 0; n < 300; n++) begin
            lfsr = next_lfsr(lfsr);
            x = lfsr;
            lfsr = next_lfsr(lfsr);
            apply_check("R1 R2 R3 R4 R6 R7 sweep", x, lfsr ^ {lfsr[15:0], lfsr[31:16]}, ops[n % 6]);
        end
    endtask

    initial begin
        t_idle();
        t_logic();
        t_add();
        t_sub();
        t_slt();
        t_zero();
        t_ovf_gated();
        t_undefined();
        t_sweep();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule